// File: doc/BRIEF.md
# Scan-Chain State Repair Controller for Triple Redundancy

This controller sits beside three identical redundant modules, each with a scan chain of `CHAIN_LEN` flops. While idle it leaves the chains alone and watches two triggers: the voter's disagreement flag and a checkpoint request. A checkpoint request can be issued during idle slack so that latent state corruption is found before it reaches an output. On either trigger it rotates all three chains for one full chain length, with each chain's output fed back to its own input. During that rotation it compares the three serial bit streams pair by pair and counts the positions at which each pair differs.

When the rotation ends, the three pair counts go to an external fault-location stage. That stage returns a faulty-module mask and a permanent-fault flag. If one or two modules are faulty, the controller routes the scan output of a healthy module into each faulty module's scan input for another full chain length. This copies the healthy state across. During the copy the same comparison runs again, but now each mismatch lowers its pair count. If every count is back at zero, the repair is trusted and the controller returns to idle. A nonzero count means another fault struck during the repair, and the controller locks into an unrecoverable mode. If a single module is reported as permanently faulty, the controller stops scanning and names that module, so that the remaining pair can run as master and checker.

Top module: `tmr_scan_recovery`

## Requirements
- R1: After synchronous reset, `mode_o` is 0 (idle), and `scan_en_o`, `loc_req_o`, `excluded_o` and all three pair counts are 0.
- R2: In idle, a high `voter_err_i` or `ckpt_req_i` at a clock edge moves the controller to compare mode (`mode_o`=1). It stays there for exactly `CHAIN_LEN` cycles with `scan_en_o`=1. Each 2-bit field k of `sci_sel_o` (bits 2k+1:2k) names the module that drives module k's scan input, and in compare mode it equals k.
- R3: The pair counts are cleared when compare mode is entered. In the single cycle after compare, `mode_o`=2 and `loc_req_o`=1, and `cnt01_o`, `cnt02_o` and `cnt12_o` each equal the number of chain positions at which that pair of modules differs.
- R4: The verdict is sampled in that cycle. A zero mask returns the controller to idle. A mask with one or two bits set starts repair (`mode_o`=3). A mask with all three bits set enters unrecoverable mode (`mode_o`=5).
- R5: During repair, each faulty module's select field names the lowest-indexed healthy module, and each healthy module's field names itself. After `CHAIN_LEN` cycles every faulty module holds the healthy module's state.
- R6: During repair, each pair mismatch lowers that pair's count by one. If all counts are zero at the end of repair, the controller returns to idle with zero counts.
- R7: If any count is nonzero at the end of repair, the controller enters unrecoverable mode (`mode_o`=5). It stays there until reset, regardless of the triggers.
- R8: A permanent-fault flag with a one-hot mask moves the controller to master/checker mode (`mode_o`=4). In that mode `excluded_o` equals the mask and `scan_en_o` is 0, and the mode lasts until reset.
- R9: A trigger that arrives during compare or repair is ignored. When the controller returns to idle with no trigger present, it stays idle.
- R10: The compare rotation leaves every module's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| voter_err_i | input | 1 | Voter disagreement flag |
| ckpt_req_i | input | 1 | Checkpoint request for a latent-fault sweep |
| scan_so_i | input | 3 | Scan outputs of modules 0..2 |
| scan_en_o | output | 1 | Shift enable for all three chains |
| sci_sel_o | output | 6 | Per-module scan input source, 2 bits per module |
| mode_o | output | 3 | Controller mode code |
| excluded_o | output | 3 | One-hot module dropped in master/checker mode |
| loc_req_o | output | 1 | Pair counts are final and the verdict is sampled |
| cnt01_o | output | CNT_W | Mismatch count for modules 0/1 |
| cnt02_o | output | CNT_W | Mismatch count for modules 0/2 |
| cnt12_o | output | CNT_W | Mismatch count for modules 1/2 |
| verdict_faulty_i | input | 3 | Faulty-module mask from the location stage |
| verdict_perm_i | input | 1 | Permanent-fault flag from the location stage |

## Verification
The assertions check the following on every cycle: the phase timer stays in range, a count never reaches the chain length during compare, each repair source is healthy, the locate cycle lasts one cycle, the terminal modes are sticky, and no compare follows repair directly. They also check that the idle-or-unrecoverable decision at the end of repair matches the zero state of the counts. Only the bench scenarios can show the rest. These are: exact pair counts for injected differences, state preserved through rotation, faulty modules actually overwritten with healthy state, and a fault injected mid-repair driving the controller into unrecoverable mode.

// File: rtl/scanrec_pkg.sv
package scanrec_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_COMPARE = 3'd1,
        MODE_LOCATE  = 3'd2,
        MODE_REPAIR  = 3'd3,
        MODE_MASTER  = 3'd4,
        MODE_DEAD    = 3'd5
    } mode_e;

    localparam int NUM_MOD  = 3;
    localparam int NUM_PAIR = 3;

    // pair 0 = (0,1), pair 1 = (0,2), pair 2 = (1,2)
    function automatic int pair_lo(input int p);
        return (p == 2) ? 1 : 0;
    endfunction

    function automatic int pair_hi(input int p);
        return (p == 0) ? 1 : 2;
    endfunction

    // lowest-indexed module not flagged faulty
    function automatic logic [1:0] healthy_src(input logic [2:0] faulty);
        if (!faulty[0]) return 2'd0;
        else if (!faulty[1]) return 2'd1;
        else return 2'd2;
    endfunction

endpackage

// File: rtl/sr_pair_counter.sv
module sr_pair_counter #(
    parameter int LEN   = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             up_i,
    input  logic             down_i,
    input  logic             bit_a_i,
    input  logic             bit_b_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o
);
    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);

    logic             diff;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign diff = bit_a_i ^ bit_b_i;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (up_i && diff)
            cnt_d = cnt_q + 1'b1;
        else if (down_i && diff)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
    assign nxt_o = cnt_d;

    // R3: at most one increment per compare cycle after clearing
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        up_i |-> (cnt_q < LEN_C));

endmodule

// File: rtl/sr_phase_timer.sv
module sr_phase_timer #(
    parameter int LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic last_o
);
    localparam int TW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [TW-1:0] LAST = TW'(LEN - 1);

    logic [TW-1:0] cnt_q;

    assign last_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || last_o) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    // R2: a scan phase never runs past its final cycle
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= LAST));

endmodule

// File: rtl/sr_scan_route.sv
module sr_scan_route
    import scanrec_pkg::*;
(
    input  logic       repair_i,
    input  logic [2:0] faulty_i,
    output logic [5:0] sel_o
);
    logic [1:0] src;
    assign src = healthy_src(faulty_i);

    for (genvar k = 0; k < NUM_MOD; k++) begin : g_mod
        assign sel_o[2*k +: 2] = (repair_i && faulty_i[k]) ? src : 2'(k);

        // R5: a repaired module never takes its state from a faulty one
        always_comb begin
            if (repair_i && faulty_i[k] && (faulty_i != 3'b111))
                p_src_healthy_r5: assert (!faulty_i[sel_o[2*k +: 2]]);
        end
    end

endmodule

// File: rtl/tmr_scan_recovery.sv
module tmr_scan_recovery
    import scanrec_pkg::*;
#(
    parameter int CHAIN_LEN = 64,
    localparam int CNT_W = $clog2(CHAIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             voter_err_i,
    input  logic             ckpt_req_i,
    input  logic [2:0]       scan_so_i,
    output logic             scan_en_o,
    output logic [5:0]       sci_sel_o,
    output logic [2:0]       mode_o,
    output logic [2:0]       excluded_o,
    output logic             loc_req_o,
    output logic [CNT_W-1:0] cnt01_o,
    output logic [CNT_W-1:0] cnt02_o,
    output logic [CNT_W-1:0] cnt12_o,
    input  logic [2:0]       verdict_faulty_i,
    input  logic             verdict_perm_i
);
    mode_e state_q, state_d;
    logic [2:0] fmr_q;
    logic       trig, clear, cmp_phase, rep_phase, phase_last, all_zero;
    logic [NUM_PAIR-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_PAIR-1:0][CNT_W-1:0] cnt_d;

    assign trig      = voter_err_i | ckpt_req_i;
    assign cmp_phase = (state_q == MODE_COMPARE);
    assign rep_phase = (state_q == MODE_REPAIR);
    assign clear     = (state_q == MODE_IDLE) && trig;
    assign scan_en_o = cmp_phase | rep_phase;
    assign all_zero  = (cnt_d == '0);

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        sr_pair_counter #(.LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clear_i (clear),
            .up_i    (cmp_phase),
            .down_i  (rep_phase),
            .bit_a_i (scan_so_i[pair_lo(p)]),
            .bit_b_i (scan_so_i[pair_hi(p)]),
            .cnt_o   (cnt_q[p]),
            .nxt_o   (cnt_d[p])
        );
    end

    sr_phase_timer #(.LEN(CHAIN_LEN)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (scan_en_o),
        .last_o (phase_last)
    );

    sr_scan_route u_route (
        .repair_i (rep_phase),
        .faulty_i (fmr_q),
        .sel_o    (sci_sel_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_IDLE:    if (trig) state_d = MODE_COMPARE;
            MODE_COMPARE: if (phase_last) state_d = MODE_LOCATE;
            MODE_LOCATE: begin
                if (verdict_perm_i && $onehot(verdict_faulty_i))
                    state_d = MODE_MASTER;
                else if (verdict_faulty_i == 3'b000)
                    state_d = MODE_IDLE;
                else if (verdict_faulty_i == 3'b111)
                    state_d = MODE_DEAD;
                else
                    state_d = MODE_REPAIR;
            end
            MODE_REPAIR:  if (phase_last) state_d = all_zero ? MODE_IDLE : MODE_DEAD;
            MODE_MASTER:  state_d = MODE_MASTER;
            MODE_DEAD:    state_d = MODE_DEAD;
            default:      state_d = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_IDLE;
            fmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == MODE_LOCATE) fmr_q <= verdict_faulty_i;
        end
    end

    assign mode_o     = state_q;
    assign loc_req_o  = (state_q == MODE_LOCATE);
    assign excluded_o = (state_q == MODE_MASTER) ? fmr_q : 3'b000;
    assign cnt01_o    = cnt_q[0];
    assign cnt02_o    = cnt_q[1];
    assign cnt12_o    = cnt_q[2];

    // R4: the verdict is taken in a single cycle
    p_locate_once_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_LOCATE) |=> (state_q != MODE_LOCATE));

    // R6: repair ends in idle exactly when every count has returned to zero
    p_clean_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (rep_phase && phase_last) |=> ((state_q == MODE_IDLE) == (cnt_q == '0)));

    // R7: unrecoverable mode is never left without reset
    p_dead_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_DEAD) |=> (state_q == MODE_DEAD));

    // R8: master/checker keeps scan idle and the excluded module fixed
    p_master_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_MASTER) |=>
            ((state_q == MODE_MASTER) && !scan_en_o && $stable(excluded_o)
             && $onehot(excluded_o)));

    // R9: a trigger during repair cannot restart comparison directly
    p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        rep_phase |=> (state_q != MODE_COMPARE));

endmodule

// File: tb/tmr_scan_recovery_tb.sv
`timescale 1ns/1ps
module tmr_scan_recovery_tb;
    localparam int LEN   = 8;
    localparam int CNT_W = $clog2(LEN + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic voter_err_i = 1'b0, ckpt_req_i = 1'b0;
    logic [2:0] verdict_faulty_i = '0;
    logic verdict_perm_i = 1'b0;
    logic scan_en_o, loc_req_o;
    logic [5:0] sci_sel_o;
    logic [2:0] mode_o, excluded_o, scan_so;
    logic [CNT_W-1:0] cnt01_o, cnt02_o, cnt12_o;

    logic [LEN-1:0] chain [3];
    logic [LEN-1:0] load_val [3];
    logic [LEN-1:0] flip [3];
    logic load_en = 1'b0;
    logic [2:0] sin;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_scan_recovery #(.CHAIN_LEN(LEN)) u_dut (
        .clk(clk), .rst(rst), .voter_err_i(voter_err_i), .ckpt_req_i(ckpt_req_i),
        .scan_so_i(scan_so), .scan_en_o(scan_en_o), .sci_sel_o(sci_sel_o),
        .mode_o(mode_o), .excluded_o(excluded_o), .loc_req_o(loc_req_o),
        .cnt01_o(cnt01_o), .cnt02_o(cnt02_o), .cnt12_o(cnt12_o),
        .verdict_faulty_i(verdict_faulty_i), .verdict_perm_i(verdict_perm_i)
    );

    // stub of the three redundant modules' scan chains
    always_comb begin
        for (int k = 0; k < 3; k++) scan_so[k] = chain[k][LEN-1];
        for (int k = 0; k < 3; k++) sin[k] = scan_so[sci_sel_o[2*k +: 2]];
    end

    always @(posedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (load_en) chain[k] <= load_val[k];
            else chain[k] <= (scan_en_o ? {chain[k][LEN-2:0], sin[k]} : chain[k]) ^ flip[k];
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int pop(input logic [LEN-1:0] v);
        int c = 0;
        for (int b = 0; b < LEN; b++) c += int'(v[b]);
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; voter_err_i = 0; ckpt_req_i = 0; verdict_perm_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_idle_reset();
        check("R1 mode", mode_o, 0);
        check("R1 scan_en", scan_en_o, 0);
        check("R1 loc_req", loc_req_o, 0);
        check("R1 excluded", excluded_o, 0);
        check("R1 counts", cnt01_o + cnt02_o + cnt12_o, 0);
    endtask

    task automatic preload(input logic [LEN-1:0] a, input logic [LEN-1:0] b, input logic [LEN-1:0] c);
        @(negedge clk);
        load_val[0] = a; load_val[1] = b; load_val[2] = c; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_case(input logic [LEN-1:0] base, input logic [LEN-1:0] e0,
                            input logic [LEN-1:0] e1, input logic [LEN-1:0] e2,
                            input logic [2:0] mask, input bit perm, input bit use_ckpt,
                            input bit inject);
        logic [LEN-1:0] orig [3];
        int hs, other, exp_sel;
        orig[0] = base ^ e0; orig[1] = base ^ e1; orig[2] = base ^ e2;
        preload(orig[0], orig[1], orig[2]);
        verdict_faulty_i = mask; verdict_perm_i = perm;
        @(negedge clk);
        if (use_ckpt) ckpt_req_i = 1'b1; else voter_err_i = 1'b1;
        @(negedge clk);
        ckpt_req_i = 1'b0; voter_err_i = 1'b0;
        check("R2 compare entered", mode_o, 1);
        check("R2 scan_en", scan_en_o, 1);
        check("R2 self-loop select", sci_sel_o, 6'b10_01_00);
        for (int c = 2; c <= LEN; c++) begin
            @(negedge clk);
            ckpt_req_i = (c == 3);   // R9: ignored mid-compare
        end
        ckpt_req_i = 1'b0;
        check("R2 compare length", mode_o, 1);
        @(negedge clk);
        check("R3 locate mode", mode_o, 2);
        check("R3 loc_req", loc_req_o, 1);
        check("R3 cnt01", cnt01_o, pop(e0 ^ e1));
        check("R3 cnt02", cnt02_o, pop(e0 ^ e2));
        check("R3 cnt12", cnt12_o, pop(e1 ^ e2));
        for (int k = 0; k < 3; k++) check("R10 state kept", chain[k], orig[k]);
        @(negedge clk);
        if (perm && $onehot(mask)) begin
            check("R8 master mode", mode_o, 4);
            check("R8 excluded", excluded_o, mask);
            check("R8 scan idle", scan_en_o, 0);
            voter_err_i = 1'b1;
            repeat (2) @(negedge clk);
            voter_err_i = 1'b0;
            check("R8 master sticky", mode_o, 4);
            check("R8 scan still idle", scan_en_o, 0);
            return;
        end
        if (mask == 3'b000) begin
            check("R4 no fault to idle", mode_o, 0);
            @(negedge clk);
            check("R9 stays idle", mode_o, 0);
            return;
        end
        if (mask == 3'b111) begin
            check("R4 all faulty dead", mode_o, 5);
            voter_err_i = 1'b1;
            repeat (2) @(negedge clk);
            voter_err_i = 1'b0;
            check("R7 dead sticky", mode_o, 5);
            return;
        end
        check("R4 repair mode", mode_o, 3);
        hs = !mask[0] ? 0 : (!mask[1] ? 1 : 2);
        other = !mask[2] ? 2 : 1;
        exp_sel = 0;
        for (int k = 0; k < 3; k++) exp_sel |= (mask[k] ? hs : k) << (2 * k);
        check("R5 repair select", sci_sel_o, exp_sel);
        if (inject) flip[other] = LEN'(1) << (LEN - 1);
        for (int c = LEN + 3; c <= 2 * LEN + 1; c++) begin
            @(negedge clk);
            flip[0] = '0; flip[1] = '0; flip[2] = '0;
            voter_err_i = (c == LEN + 4);   // R9: ignored mid-repair
        end
        voter_err_i = 1'b0;
        check("R5 repair length", mode_o, 3);
        @(negedge clk);
        if (inject) begin
            check("R7 fault in repair", mode_o, 5);
            ckpt_req_i = 1'b1;
            repeat (2) @(negedge clk);
            ckpt_req_i = 1'b0;
            check("R7 dead sticky", mode_o, 5);
        end else begin
            check("R6 back to idle", mode_o, 0);
            check("R6 counts zero", cnt01_o + cnt02_o + cnt12_o, 0);
            for (int k = 0; k < 3; k++) check("R5 state copied", chain[k], base);
            @(negedge clk);
            check("R9 stays idle", mode_o, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [LEN-1:0] base, pat [3];
        for (int k = 0; k < 3; k++) begin flip[k] = '0; load_val[k] = '0; end
        do_reset();
        @(negedge clk);
        check_idle_reset();

        // sweep every fault mask except all-faulty, several patterns each
        for (int m = 0; m < 7; m++) begin
            for (int s = 0; s < 4; s++) begin
                base = LEN'(m * 47 + s * 83 + 19);
                for (int k = 0; k < 3; k++) begin
                    pat[k] = LEN'((s * 5 + k * 3 + m) * 29 + 7 + k);
                    if (pat[k] == '0) pat[k] = 1;
                    if (!m[k]) pat[k] = '0;
                end
                run_case(base, pat[0], pat[1], pat[2], 3'(m), 1'b0, s[0], 1'b0);
            end
        end

        // fault striking a healthy module during repair
        for (int m = 1; m <= 4; m = m * 2) begin
            run_case(LEN'(8'h5A + m), (m == 1) ? LEN'(8'h11) : '0,
                     (m == 2) ? LEN'(8'h24) : '0, (m == 4) ? LEN'(8'h81) : '0,
                     3'(m), 1'b0, 1'b0, 1'b1);
            do_reset();
        end

        // permanent fault on a single module
        run_case(LEN'(8'h3C), '0, LEN'(8'h0F), '0, 3'b010, 1'b1, 1'b0, 1'b0);
        do_reset();
        // permanent flag with two faulty modules repairs normally (R8 needs one-hot)
        run_case(LEN'(8'hC3), LEN'(8'h01), LEN'(8'h80), '0, 3'b011, 1'b1, 1'b1, 1'b0);

        // all three reported faulty
        run_case(LEN'(8'h77), LEN'(8'h01), LEN'(8'h02), LEN'(8'h04), 3'b111, 1'b0, 1'b0, 1'b0);
        do_reset();
        @(negedge clk);
        check_idle_reset();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule